// File: doc/BRIEF.md
# Bus Error Capture and Interrupt

This block sits beside an external bus controller and records the first bus fault that it reports. Five fault inputs arrive already detected, each with the address, data and parity of the access that failed. These are a data parity fault, an address that hits no configured window, an address that hits several windows, an acknowledge that never came, and a coherent cacheable access whose response showed both shared and exclusive ownership. When one of them fires and no earlier fault is still waiting, the block stores that access's values. It also stores a 3-bit cause code and raises one level-sensitive interrupt.

Faults that arrive while one is still waiting are dropped, so the stored record always describes the first fault. The block never holds up the bus. Software reads the record through a small register read port: the address, data and parity views first, then the status view. A status read that is not flagged cacheable returns the cause and the pending bit, then clears both on the same clock edge. A cacheable status read returns the same value and leaves everything as it was.

Top module: `bus_err_capture`

## Requirements
- R1: After reset the interrupt is low and a status read returns zero (pending bit 0, cause 0).
- R2: A fault on input i (0..4) while nothing is pending raises the interrupt on the next clock edge and records cause i+1: 1 parity, 2 no window hit, 3 several windows hit, 4 acknowledge timeout, 5 ownership conflict.
- R3: The captured address, data and parity of the winning input are returned, zero-extended to the read width, by reads with select 0, 1 and 2 respectively.
- R4: When several fault inputs assert in the same cycle, the lowest-numbered input wins and only its values are captured.
- R5: While a fault is pending, further faults are ignored: the interrupt stays high and the cause and captured values do not change.
- R6: A status read (select 3) with the cacheable flag low returns the cause in bits 3:1 and the pending flag in bit 0, and clears the pending flag and cause on that edge, so the interrupt is low one cycle later.
- R7: A status read with the cacheable flag high returns the same status value but clears nothing.
- R8: Reads with select 0, 1 or 2 have no side effect on the interrupt or on the stored record.
- R9: Each read returns its data, with the read-valid flag high, in the cycle after the request.
- R10: A fault that coincides with a clearing status read is dropped, and the captured address, data and parity stay readable after a clear until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_vld_i | input | 5 | Fault strobes; bit i is cause i+1 |
| err_addr_i | input | 5*ADDR_W | Failing addresses, input i at bits i*ADDR_W upward |
| err_data_i | input | 5*DATA_W | Failing data, packed the same way |
| err_par_i | input | 5*PAR_W | Failing parity, packed the same way |
| rd_en_i | input | 1 | Register read request |
| rd_sel_i | input | 2 | Read select: 0 address, 1 data, 2 parity, 3 status |
| rd_cacheable_i | input | 1 | Read is cacheable (a status read then does not clear) |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DATA_W | Read data |
| irq_o | output | 1 | Level interrupt, high while a fault is pending |

## Verification
A fault strobe is taken on one rising edge, and the interrupt and stored record change on that same edge. A read request is taken on an edge, and its data and valid flag are registered on that edge too. The clear from a status read lands on that edge as well. The bench drives inputs on the falling edge and updates its model of pending state and record at the next rising edge. At the following falling edge it compares the interrupt against the updated model and the read data against the value the model held before that edge. A status read therefore shows the pre-clear value, while the interrupt already shows the cleared state.

// File: rtl/bec_pkg.sv
package bec_pkg;

   localparam int unsigned BEC_NSRC    = 5;
   localparam int unsigned BEC_CAUSE_W = 3;

   typedef enum logic [BEC_CAUSE_W-1:0] {
      CAUSE_NONE     = 3'd0,
      CAUSE_PARITY   = 3'd1,
      CAUSE_NO_HIT   = 3'd2,
      CAUSE_MULTIHIT = 3'd3,
      CAUSE_ACK_TO   = 3'd4,
      CAUSE_OWNER    = 3'd5
   } bec_cause_e;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_PAR  = 2'd2,
      SEL_STAT = 2'd3
   } bec_sel_e;

endpackage

// File: rtl/bec_prio.sv
module bec_prio
   import bec_pkg::*;
#(
   parameter int unsigned NSRC    = BEC_NSRC,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned PAR_W   = 8,
   parameter int unsigned CAUSE_W = BEC_CAUSE_W
) (
   input  logic [NSRC-1:0]        vld_i,
   input  logic [NSRC*ADDR_W-1:0] addr_i,
   input  logic [NSRC*DATA_W-1:0] data_i,
   input  logic [NSRC*PAR_W-1:0]  par_i,
   output logic                   hit_o,
   output logic [CAUSE_W-1:0]     cause_o,
   output logic [ADDR_W-1:0]      addr_o,
   output logic [DATA_W-1:0]      data_o,
   output logic [PAR_W-1:0]       par_o
);

   logic [NSRC:0]   seen;
   logic [NSRC-1:0] gnt;

   assign seen[0] = 1'b0;

   for (genvar g = 0; g < NSRC; g++) begin : g_chain
      assign seen[g+1] = seen[g] | vld_i[g];
      assign gnt[g]    = vld_i[g] & ~seen[g];
   end

   assign hit_o = seen[NSRC];

   always_comb begin
      cause_o = '0;
      addr_o  = '0;
      data_o  = '0;
      par_o   = '0;
      for (int i = 0; i < NSRC; i++) begin
         cause_o = cause_o | (gnt[i] ? CAUSE_W'(i + 1) : '0);
         addr_o  = addr_o  | ({ADDR_W{gnt[i]}} & addr_i[i*ADDR_W +: ADDR_W]);
         data_o  = data_o  | ({DATA_W{gnt[i]}} & data_i[i*DATA_W +: DATA_W]);
         par_o   = par_o   | ({PAR_W{gnt[i]}}  & par_i[i*PAR_W +: PAR_W]);
      end
   end

endmodule

// File: rtl/bec_hold.sv
module bec_hold
   import bec_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned PAR_W   = 8,
   parameter int unsigned CAUSE_W = BEC_CAUSE_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               hit_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  data_i,
   input  logic [PAR_W-1:0]   par_i,
   input  logic               clr_i,
   output logic               pend_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [DATA_W-1:0]  data_o,
   output logic [PAR_W-1:0]   par_o
);

   logic take;

   // capture only from the idle state; a pending record blocks all new faults
   assign take = hit_i & ~pend_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_o  <= 1'b0;
         cause_o <= '0;
      end else if (pend_o && clr_i) begin
         pend_o  <= 1'b0;
         cause_o <= '0;
      end else if (take) begin
         pend_o  <= 1'b1;
         cause_o <= cause_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_o <= '0;
         data_o <= '0;
         par_o  <= '0;
      end else if (take) begin
         addr_o <= addr_i;
         data_o <= data_i;
         par_o  <= par_i;
      end
   end

endmodule

// File: rtl/bec_rdport.sv
module bec_rdport
   import bec_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned PAR_W   = 8,
   parameter int unsigned CAUSE_W = BEC_CAUSE_W,
   parameter bit          RD_REG  = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               rd_en_i,
   input  logic [1:0]         rd_sel_i,
   input  logic               rd_cacheable_i,
   input  logic               pend_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  data_i,
   input  logic [PAR_W-1:0]   par_i,
   output logic               clr_o,
   output logic               rd_valid_o,
   output logic [DATA_W-1:0]  rd_data_o
);

   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] mux;

   assign clr_o = rd_en_i & (bec_sel_e'(rd_sel_i) == SEL_STAT) & ~rd_cacheable_i;

   always_comb begin
      stat_word              = '0;
      stat_word[0]           = pend_i;
      stat_word[CAUSE_W:1]   = cause_i;
   end

   always_comb begin
      unique case (bec_sel_e'(rd_sel_i))
         SEL_ADDR: mux = DATA_W'(addr_i);
         SEL_DATA: mux = data_i;
         SEL_PAR:  mux = DATA_W'(par_i);
         default:  mux = stat_word;
      endcase
   end

   if (RD_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
         end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) rd_data_o <= mux;
         end
      end
   end else begin : g_comb
      assign rd_valid_o = rd_en_i;
      assign rd_data_o  = rd_en_i ? mux : '0;
   end

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
   import bec_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned PAR_W  = 8,
   parameter bit          RD_REG = 1'b1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [BEC_NSRC-1:0]        err_vld_i,
   input  logic [BEC_NSRC*ADDR_W-1:0] err_addr_i,
   input  logic [BEC_NSRC*DATA_W-1:0] err_data_i,
   input  logic [BEC_NSRC*PAR_W-1:0]  err_par_i,
   input  logic                       rd_en_i,
   input  logic [1:0]                 rd_sel_i,
   input  logic                       rd_cacheable_i,
   output logic                       rd_valid_o,
   output logic [DATA_W-1:0]          rd_data_o,
   output logic                       irq_o
);

   localparam int unsigned CAUSE_W = BEC_CAUSE_W;
   localparam int unsigned STAT_W  = CAUSE_W + 1;

   if (DATA_W < ADDR_W) begin : g_chk_addr
      $error("bus_err_capture: DATA_W must cover ADDR_W");
   end
   if (DATA_W < PAR_W) begin : g_chk_par
      $error("bus_err_capture: DATA_W must cover PAR_W");
   end
   if (DATA_W < STAT_W) begin : g_chk_stat
      $error("bus_err_capture: DATA_W too narrow for status word");
   end
   if (BEC_NSRC >= (1 << CAUSE_W)) begin : g_chk_cause
      $error("bus_err_capture: cause field too narrow for source count");
   end

   logic               hit;
   logic [CAUSE_W-1:0] win_cause;
   logic [ADDR_W-1:0]  win_addr;
   logic [DATA_W-1:0]  win_data;
   logic [PAR_W-1:0]   win_par;
   logic               clr;
   logic               pend_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [ADDR_W-1:0]  cap_addr;
   logic [DATA_W-1:0]  cap_data;
   logic [PAR_W-1:0]   cap_par;

   bec_prio #(
      .NSRC   (BEC_NSRC),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PAR_W  (PAR_W),
      .CAUSE_W(CAUSE_W)
   ) prio_i (
      .vld_i  (err_vld_i),
      .addr_i (err_addr_i),
      .data_i (err_data_i),
      .par_i  (err_par_i),
      .hit_o  (hit),
      .cause_o(win_cause),
      .addr_o (win_addr),
      .data_o (win_data),
      .par_o  (win_par)
   );

   bec_hold #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PAR_W  (PAR_W),
      .CAUSE_W(CAUSE_W)
   ) hold_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit),
      .cause_i(win_cause),
      .addr_i (win_addr),
      .data_i (win_data),
      .par_i  (win_par),
      .clr_i  (clr),
      .pend_o (pend_q),
      .cause_o(cause_q),
      .addr_o (cap_addr),
      .data_o (cap_data),
      .par_o  (cap_par)
   );

   bec_rdport #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PAR_W  (PAR_W),
      .CAUSE_W(CAUSE_W),
      .RD_REG (RD_REG)
   ) rdport_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .rd_en_i       (rd_en_i),
      .rd_sel_i      (rd_sel_i),
      .rd_cacheable_i(rd_cacheable_i),
      .pend_i        (pend_q),
      .cause_i       (cause_q),
      .addr_i        (cap_addr),
      .data_i        (cap_data),
      .par_i         (cap_par),
      .clr_o         (clr),
      .rd_valid_o    (rd_valid_o),
      .rd_data_o     (rd_data_o)
   );

   assign irq_o = pend_q;

endmodule

// File: rtl/bec_chk.sv
module bec_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned PAR_W   = 8,
   parameter int unsigned CAUSE_W = 3,
   parameter bit          RD_REG  = 1'b1
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [4:0]         err_vld_i,
   input logic               rd_en_i,
   input logic [1:0]         rd_sel_i,
   input logic               rd_cacheable_i,
   input logic               rd_valid_o,
   input logic               irq_o,
   input logic [CAUSE_W-1:0] cause_q,
   input logic [ADDR_W-1:0]  cap_addr,
   input logic [DATA_W-1:0]  cap_data,
   input logic [PAR_W-1:0]   cap_par
);

   logic clr_rd;
   logic keep_rd;
   assign clr_rd  = rd_en_i && (rd_sel_i == 2'd3) && !rd_cacheable_i;
   assign keep_rd = rd_en_i && (rd_sel_i == 2'd3) && rd_cacheable_i;

   AST_FAULT_SETS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!irq_o && (err_vld_i != 5'd0)) |=> irq_o) else $error("AST_FAULT_SETS_IRQ"); // R2

   AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (cause_q >= CAUSE_W'(1) && cause_q <= CAUSE_W'(5))) else $error("AST_CAUSE_LEGAL"); // R2

   AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!irq_o && err_vld_i[0]) |=> (cause_q == CAUSE_W'(1))) else $error("AST_LOWEST_WINS"); // R4

   AST_RECORD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> ($stable(cap_addr) && $stable(cap_data) && $stable(cap_par))) else $error("AST_RECORD_FROZEN"); // R5

   AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !clr_rd) |=> (irq_o && $stable(cause_q))) else $error("AST_PEND_HOLDS"); // R5

   AST_CLEAR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && clr_rd) |=> (!irq_o && cause_q == '0)) else $error("AST_CLEAR_READ"); // R6

   AST_CACHED_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && keep_rd) |=> irq_o) else $error("AST_CACHED_KEEPS"); // R7

   AST_IDLE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o |-> (cause_q == '0)) else $error("AST_IDLE_CAUSE"); // R1

   if (RD_REG) begin : g_lat
      AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rd_en_i |=> rd_valid_o) else $error("AST_READ_LATENCY"); // R9
   end

endmodule

bind bus_err_capture bec_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .PAR_W  (PAR_W),
   .CAUSE_W(CAUSE_W),
   .RD_REG (RD_REG)
) chk_i (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .err_vld_i     (err_vld_i),
   .rd_en_i       (rd_en_i),
   .rd_sel_i      (rd_sel_i),
   .rd_cacheable_i(rd_cacheable_i),
   .rd_valid_o    (rd_valid_o),
   .irq_o         (irq_o),
   .cause_q       (cause_q),
   .cap_addr      (cap_addr),
   .cap_data      (cap_data),
   .cap_par       (cap_par)
);

// File: tb/bus_err_capture_tb_top.sv
module bus_err_capture_tb_top;

   localparam int unsigned AW = 32;
   localparam int unsigned DW = 64;
   localparam int unsigned PW = 8;
   localparam int unsigned NS = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NS-1:0]     vld = '0;
   logic [NS*AW-1:0]  addr_f;
   logic [NS*DW-1:0]  data_f;
   logic [NS*PW-1:0]  par_f;
   logic              rd_en = 1'b0;
   logic [1:0]        rd_sel = 2'd0;
   logic              rd_cach = 1'b0;
   logic              rd_valid;
   logic [DW-1:0]     rd_data;
   logic              irq;

   logic [AW-1:0] a_src [NS];
   logic [DW-1:0] d_src [NS];
   logic [PW-1:0] p_src [NS];

   // bench model
   logic          m_pend;
   logic [2:0]    m_cause;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_data;
   logic [PW-1:0] m_par;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NS; i++) begin
         addr_f[i*AW +: AW] = a_src[i];
         data_f[i*DW +: DW] = d_src[i];
         par_f[i*PW +: PW]  = p_src[i];
      end
   end

   bus_err_capture #(.ADDR_W(AW), .DATA_W(DW), .PAR_W(PW), .RD_REG(1'b1)) dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .err_vld_i     (vld),
      .err_addr_i    (addr_f),
      .err_data_i    (data_f),
      .err_par_i     (par_f),
      .rd_en_i       (rd_en),
      .rd_sel_i      (rd_sel),
      .rd_cacheable_i(rd_cach),
      .rd_valid_o    (rd_valid),
      .rd_data_o     (rd_data),
      .irq_o         (irq)
   );

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_read(input logic [1:0] sel);
      case (sel)
         2'd0:    return DW'(m_addr);
         2'd1:    return m_data;
         2'd2:    return DW'(m_par);
         default: return DW'({m_cause, m_pend});
      endcase
   endfunction

   function automatic int lowest(input logic [NS-1:0] v);
      for (int i = 0; i < NS; i++) if (v[i]) return i;
      return -1;
   endfunction

   // one clock: drive at falling edge, model at rising, check at next falling
   task automatic step(input logic [NS-1:0] v, input bit re, input logic [1:0] sel, input bit cach,
                       input string tag);
      logic [DW-1:0] pred;
      bit clr;
      int w;
      vld = v; rd_en = re; rd_sel = sel; rd_cach = cach;
      pred = exp_read(sel);
      clr  = re && sel == 2'd3 && !cach;
      w    = lowest(v);
      @(posedge clk);
      if (m_pend && clr) begin
         m_pend = 1'b0; m_cause = 3'd0;
      end else if (!m_pend && w >= 0) begin
         m_pend = 1'b1; m_cause = 3'(w + 1);
         m_addr = a_src[w]; m_data = d_src[w]; m_par = p_src[w];
      end
      @(negedge clk);
      check(irq == m_pend, {tag, " irq"}, DW'(irq), DW'(m_pend));
      check(rd_valid == re, "R9 rd_valid", DW'(rd_valid), DW'(re));
      if (re) check(rd_data == pred, (sel == 2'd3) ? "R6/R7 status" : "R3 record", rd_data, pred);
      vld = '0; rd_en = 1'b0;
   endtask

   task automatic new_values();
      for (int i = 0; i < NS; i++) begin
         a_src[i] = $urandom;
         d_src[i] = {$urandom, $urandom};
         p_src[i] = PW'($urandom);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL R9 watchdog act=hung exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20250611));
      m_pend = 1'b0; m_cause = '0; m_addr = '0; m_data = '0; m_par = '0;
      new_values();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state
      check(irq == 1'b0, "R1 irq after reset", DW'(irq), '0);
      step('0, 1'b1, 2'd3, 1'b0, "R1");
      check(rd_data == '0, "R1 status after reset", rd_data, '0);

      // R2: single fault from input 2 gives cause 3
      step(5'b00100, 1'b0, 2'd0, 1'b0, "R2");
      step('0, 1'b1, 2'd3, 1'b1, "R7");
      check(rd_data == DW'(7), "R2 cause 3 pending", rd_data, DW'(7));
      check(irq == 1'b1, "R7 cacheable read keeps irq", DW'(irq), DW'(1));
      // R8: record reads leave state alone
      step('0, 1'b1, 2'd0, 1'b0, "R8");
      check(rd_data == DW'(a_src[2]), "R3 address", rd_data, DW'(a_src[2]));
      step('0, 1'b1, 2'd1, 1'b0, "R8");
      step('0, 1'b1, 2'd2, 1'b0, "R8");
      check(irq == 1'b1, "R8 irq after record reads", DW'(irq), DW'(1));
      // R5: later fault ignored
      step(5'b00001, 1'b0, 2'd0, 1'b0, "R5");
      step('0, 1'b1, 2'd0, 1'b1, "R5");
      check(rd_data == DW'(a_src[2]), "R5 record unchanged", rd_data, DW'(a_src[2]));
      // R10: clearing read with a simultaneous fault
      step(5'b10000, 1'b1, 2'd3, 1'b0, "R10");
      check(rd_data == DW'(7), "R6 status before clear", rd_data, DW'(7));
      check(irq == 1'b0, "R10 fault dropped at clear", DW'(irq), '0);
      step('0, 1'b1, 2'd0, 1'b0, "R10");
      check(rd_data == DW'(a_src[2]), "R10 record kept after clear", rd_data, DW'(a_src[2]));
      // R4: all inputs at once
      new_values();
      step(5'b11111, 1'b0, 2'd0, 1'b0, "R4");
      step('0, 1'b1, 2'd3, 1'b0, "R4");
      check(rd_data == DW'(3), "R4 lowest input wins", rd_data, DW'(3));
      step(5'b11110, 1'b0, 2'd0, 1'b0, "R2");
      step('0, 1'b1, 2'd1, 1'b1, "R4");
      check(rd_data == d_src[1], "R4 data of input 1", rd_data, d_src[1]);
      step('0, 1'b1, 2'd3, 1'b0, "R6");

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         logic [NS-1:0] v;
         for (int b = 0; b < NS; b++) v[b] = ($urandom % 8) == 0;
         if (($urandom % 16) == 0) new_values();
         step(v, ($urandom % 2) == 0, 2'($urandom), ($urandom % 4) == 0, "R2/R5/R6");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule